// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit down-counter with a reload latch, driven from an 8-bit register bus. One counter serves four modes. In interval mode it steps on a divide-by-16 enable from the clock tree. In pulse mode it does the same and also flips an output pin at each underflow. In event mode it steps on edges of an external pin. In width mode it steps on the prescaled enable only while the pin sits at a chosen level. An underflow is a step taken from zero. On that step the counter reloads from the latch and raises a one-cycle interrupt strobe. A second strobe reports the selected edge of the pin.

Software moves 16-bit values one byte at a time, in a fixed order. A low-byte write is parked until the high byte arrives, and then both bytes commit in one cycle. Reading the high byte freezes a copy of the low byte, so the next low-byte read belongs to the same count. A write-control bit chooses where a committed value goes: into the counter and the latch together, or into the latch alone, with the counter taking it at the next underflow. The pin input passes through a two-stage synchronizer before any edge or level is taken from it.

Bus map (byte addresses): 0 is the counter low byte, 1 is the counter high byte, 2 is the control byte, and 3 reads as zero.

Top module: `mtimer16`

## Requirements
- R1: After reset the control byte reads 0x00, both counter bytes read 0xFF, cntr_out is 1, and uf_irq and edge_irq are 0.
- R2: Control byte layout: bit 7 stop, bit 6 edge select, bits 5:4 mode (00 interval, 01 pulse, 10 event, 11 width), bits 3:1 reserved and always read 0, bit 0 latch-only. The control byte reads back what was written, except for the reserved bits.
- R3: A write to address 0 on its own changes neither the counter nor the latch. The following write to address 1 commits {high byte, parked low byte} as one 16-bit value.
- R4: With latch-only at 0, a commit loads both the counter and the latch in the same cycle.
- R5: With latch-only at 1, a commit loads only the latch. The counter keeps its value until its next underflow, and that underflow reloads it with the new latch value.
- R6: A read at address 1 returns the live high byte and freezes the low byte. Later reads at address 0 return the frozen byte even if the counter has moved since.
- R7: In interval mode with stop at 0, each cycle with presc_en high lowers a non-zero count by one. The update shows on the clock edge that samples presc_en.
- R8: A step taken from 0x0000 reloads the latch value instead of wrapping, and raises uf_irq for exactly one cycle.
- R9: In pulse mode cntr_out inverts at every underflow. Every control write sets cntr_out to the inverse of edge select (0 gives high, 1 gives low). Underflows in other modes leave cntr_out unchanged.
- R10: In event mode the counter steps once per synchronized rising edge of cntr_in when edge select is 0, and once per falling edge when it is 1. presc_en has no effect in this mode.
- R11: In width mode the counter steps on presc_en only while the synchronized cntr_in is high (edge select 0) or low (edge select 1).
- R12: With stop at 1 the counter holds in every mode.
- R13: edge_irq pulses for one cycle on each synchronized falling edge of cntr_in when edge select is 0, and on each rising edge when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_en | input | 1 | Divide-by-16 count enable, one cycle per period |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (a read at address 1 freezes the low byte) |
| bus_addr | input | 2 | Byte address: 0 low, 1 high, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cntr_in | input | 1 | External pin input, asynchronous |
| cntr_out | output | 1 | Pulse output pin |
| uf_irq | output | 1 | One-cycle underflow strobe |
| edge_irq | output | 1 | One-cycle pin edge strobe |

## Verification
A count step, a commit and a control write all take effect on the clock edge that samples them. Read data is combinational, so the bench samples it 1 ns after the falling edge, before the edge that could move the counter. A change on cntr_in passes two synchronizer stages and one edge register before it can step the counter, about three edges in all, so the bench waits five cycles after every pin change before it pulses or reads. The two strobes are registered one edge after their cause. Monitors running on the falling edge count them, and the bench compares those totals with the underflow and edge counts that its own reference model predicts.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_PULSE = 2'b01,
    MD_EVENT = 2'b10,
    MD_WIDTH = 2'b11
  } mtm_mode_e;

  typedef struct packed {
    logic      stop;
    logic      edge_sel;
    mtm_mode_e mode;
    logic [2:0] rsvd;
    logic      latch_only;
  } mtm_ctrl_t;

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  // Next value of the counter on an enabled step: reload from zero.
  function automatic logic [15:0] step_value(input logic [15:0] cnt,
                                             input logic [15:0] lat);
    return (cnt == 16'h0000) ? lat : (cnt - 16'h0001);
  endfunction

  // Per-cycle step enable from mode and synchronized pin events.
  function automatic logic step_gate(input mtm_ctrl_t c, input logic presc,
                                     input logic rise, input logic fall,
                                     input logic level);
    logic g;
    case (c.mode)
      MD_TIMER, MD_PULSE: g = presc;
      MD_EVENT:           g = c.edge_sel ? fall : rise;
      MD_WIDTH:           g = presc & (level ^ c.edge_sel);
      default:            g = 1'b0;
    endcase
    return g & ~c.stop;
  endfunction

  // Control write with reserved bits cleared.
  function automatic mtm_ctrl_t ctrl_clean(input logic [7:0] d);
    mtm_ctrl_t c;
    c = mtm_ctrl_t'(d);
    c.rsvd = 3'b000;
    return c;
  endfunction

endpackage

// File: rtl/mtm_sync_edge.sv
module mtm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/mtm_regif.sv
module mtm_regif
  import mtm_pkg::*;
#(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [CW-1:0] cnt,
  output logic          commit,
  output logic [CW-1:0] commit_val,
  output logic          ctrl_wr,
  output mtm_ctrl_t     ctrl
);
  logic [BW-1:0] lo_park_q;
  logic [BW-1:0] lo_snap_q;

  assign commit     = bus_wr && (bus_addr == A_HI);
  assign commit_val = {bus_wdata, lo_park_q};
  assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_park_q <= '1;
      lo_snap_q <= '1;
      ctrl      <= '0;
    end else begin
      if (bus_wr && bus_addr == A_LO) lo_park_q <= bus_wdata;
      if (ctrl_wr)                    ctrl <= ctrl_clean(bus_wdata[7:0]);
      if (bus_rd && bus_addr == A_HI) lo_snap_q <= cnt[BW-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO:    bus_rdata = lo_snap_q;
      A_HI:    bus_rdata = cnt[CW-1:BW];
      A_CTRL:  bus_rdata = BW'(ctrl);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mtm_core.sv
module mtm_core
  import mtm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          commit,
  input  logic [CW-1:0] commit_val,
  input  logic          latch_only,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] latch,
  output logic          uf_event,
  output logic          uf_irq
);
  assign uf_event = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '1;
      latch  <= '1;
      uf_irq <= 1'b0;
    end else begin
      uf_irq <= uf_event;
      if (commit) latch <= commit_val;
      if (commit && (!latch_only || uf_event))
        cnt <= commit_val;             // immediate load, or reload meets new latch
      else if (tick)
        cnt <= step_value(cnt, latch);
    end
  end
endmodule

// File: rtl/mtimer16.sv
module mtimer16
  import mtm_pkg::*;
#(
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          presc_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          cntr_in,
  output logic          cntr_out,
  output logic          uf_irq,
  output logic          edge_irq
);
  // Named internal events, visible to the bound checker.
  logic          pin_lvl_w, pin_rise_w, pin_fall_w;
  logic          tick_w, commit_w, ctrl_wr_w, uf_evt_w, toggle_w, pulse_mode_w;
  logic [CW-1:0] cnt_w, latch_w, commit_val_w;
  mtm_ctrl_t     ctrl_w;

  mtm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cntr_in),
    .level(pin_lvl_w), .rise(pin_rise_w), .fall(pin_fall_w)
  );

  mtm_regif #(.BW(BW)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_w), .commit(commit_w), .commit_val(commit_val_w),
    .ctrl_wr(ctrl_wr_w), .ctrl(ctrl_w)
  );

  assign tick_w = step_gate(ctrl_w, presc_en, pin_rise_w, pin_fall_w, pin_lvl_w);

  mtm_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_w),
    .commit(commit_w), .commit_val(commit_val_w),
    .latch_only(ctrl_w.latch_only),
    .cnt(cnt_w), .latch(latch_w), .uf_event(uf_evt_w), .uf_irq(uf_irq)
  );

  assign pulse_mode_w = (ctrl_w.mode == MD_PULSE);
  assign toggle_w     = uf_evt_w && pulse_mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntr_out <= 1'b1;
      edge_irq <= 1'b0;
    end else begin
      edge_irq <= ctrl_w.edge_sel ? pin_rise_w : pin_fall_w;
      if (ctrl_wr_w)     cntr_out <= ~bus_wdata[6];
      else if (toggle_w) cntr_out <= ~cntr_out;
    end
  end
endmodule

// File: rtl/mtm_chk.sv
module mtm_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          commit,
  input logic          ctrl_wr,
  input logic          stop,
  input logic          pulse_mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] latch,
  input logic          pulse,
  input logic          uf_irq
);
  // R8: strobe only follows a step taken from zero
  p_uf_from_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_irq |-> $past(tick && cnt == '0));

  // R8: a step from zero reloads the latch
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !commit) |=> (cnt == $past(latch)));

  // R7: a step from a non-zero count lowers it by one
  p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !commit) |=> (cnt == $past(cnt) - 1'b1));

  // R12: stop holds the count
  p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !commit) |=> $stable(cnt));

  // R9: pin output moves only on control writes or pulse-mode underflow
  p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !(pulse_mode && tick && cnt == '0)) |=> $stable(pulse));
endmodule

bind mtimer16 mtm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .commit(commit_w),
  .ctrl_wr(ctrl_wr_w), .stop(ctrl_w.stop), .pulse_mode(pulse_mode_w),
  .cnt(cnt_w), .latch(latch_w), .pulse(cntr_out), .uf_irq(uf_irq)
);

// File: tb/tb_mtimer16.sv
`timescale 1ns/1ps
module tb_mtimer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       presc_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, cntr_in = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cntr_out, uf_irq, edge_irq;

  int total = 0, bad = 0, uf_seen = 0, edge_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mtimer16 dut (
    .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cntr_in(cntr_in), .cntr_out(cntr_out),
    .uf_irq(uf_irq), .edge_irq(edge_irq)
  );

  always @(negedge clk) begin
    if (uf_irq)   uf_seen++;
    if (edge_irq) edge_seen++;
  end

  // Control byte: stop b7, edge select b6, mode b5:4, latch-only b0.
  function automatic logic [7:0] ctl(bit stop, bit sel, bit [1:0] md, bit lo);
    return {stop, sel, md, 3'b000, lo};
  endfunction

  // Reference: n enabled steps from v with reload value lat.
  function automatic int unsigned ref_steps(int unsigned v, int unsigned lat,
                                            int n, output int ufs);
    ufs = 0;
    for (int i = 0; i < n; i++) begin
      if (v == 0) begin v = lat; ufs++; end
      else v = v - 1;
    end
    return v;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wr16(logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd0, l);
    v = {h, l};
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); presc_en = 1'b1;
      @(posedge clk); #1 presc_en = 1'b0;
    end
  endtask

  task automatic pin(logic v);
    @(negedge clk); cntr_in = v;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int          ufs, u0, e0;
    int unsigned exp;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cntr_out", cntr_out, 1);
    chk("R1 strobes", {uf_irq, edge_irq}, 0);
    rd(2'd2, b); chk("R1 ctrl", b, 8'h00);
    rd16(v);     chk("R1 counter", v, 16'hFFFF);

    // R2 control readback, reserved bits zero
    wr(2'd2, 8'hFF); rd(2'd2, b); chk("R2 reserved", b, 8'hF1);
    wr(2'd2, ctl(1, 0, 2'b10, 0)); rd(2'd2, b); chk("R2 readback", b, 8'hA0);

    // R3/R4 ordered write, immediate load
    wr(2'd2, ctl(1, 0, 2'b00, 0));
    wr16(16'h1234);
    wr(2'd0, 8'h99);
    rd16(v); chk("R3 low alone", v, 16'h1234);
    wr(2'd1, 8'h56);
    rd16(v); chk("R3 R4 commit", v, 16'h5699);

    // R12 stop holds
    pulses(10); rd16(v); chk("R12 stopped", v, 16'h5699);

    // R5 latch-only
    wr16(16'h0005);
    wr(2'd2, ctl(0, 0, 2'b00, 1));
    wr16(16'h0100);
    rd16(v); chk("R5 counter kept", v, 16'h0005);
    u0 = uf_seen;
    pulses(5); rd16(v); chk("R5 before uf", v, 16'h0000);
    pulses(1); rd16(v); chk("R5 reload", v, 16'h0100);
    @(negedge clk); chk("R8 one strobe", uf_seen - u0, 1);

    // R6 coherent read: low byte frozen at high read
    wr(2'd2, ctl(0, 0, 2'b00, 0));
    rd(2'd1, b); chk("R6 high", b, 8'h01);
    pulses(1);
    rd(2'd0, b); chk("R6 frozen low", b, 8'h00);
    rd(2'd1, b); chk("R6 live high", b, 8'h00);

    // R7/R8 random interval runs against the reference model
    for (int it = 0; it < 24; it++) begin
      int n;
      logic [15:0] s;
      s = (it % 3 == 0) ? 16'($urandom % 4) : 16'($urandom);
      n = $urandom % 40;
      wr(2'd2, ctl(1, 0, 2'b00, 0));
      wr16(s);
      wr(2'd2, ctl(0, 0, 2'b00, 0));
      u0 = uf_seen;
      pulses(n);
      wr(2'd2, ctl(1, 0, 2'b00, 0));
      exp = ref_steps(s, s, n, ufs);
      rd16(v); chk("R7 R8 random count", v, exp);
      chk("R8 random strobes", uf_seen - u0, ufs);
    end

    // R9 pulse output
    wr(2'd2, ctl(1, 0, 2'b01, 0)); wr16(16'h0002);
    wr(2'd2, ctl(0, 0, 2'b01, 0));
    @(negedge clk); chk("R9 start high", cntr_out, 1);
    pulses(3); @(negedge clk); chk("R9 toggle low", cntr_out, 0);
    pulses(3); @(negedge clk); chk("R9 toggle high", cntr_out, 1);
    wr(2'd2, ctl(1, 1, 2'b01, 0));
    @(negedge clk); chk("R9 start low", cntr_out, 0);
    wr(2'd2, ctl(0, 1, 2'b00, 0));
    @(negedge clk); chk("R9 sel1 level", cntr_out, 0);
    pulses(3); @(negedge clk); chk("R9 timer no toggle", cntr_out, 0);

    // R10/R13 event counting
    wr(2'd2, ctl(1, 0, 2'b10, 0)); wr16(16'd10);
    wr(2'd2, ctl(0, 0, 2'b10, 0));
    e0 = edge_seen;
    for (int k = 0; k < 3; k++) begin pin(1); pin(0); end
    rd16(v); chk("R10 rising", v, 16'd7);
    chk("R13 falling irq", edge_seen - e0, 3);
    pulses(4); rd16(v); chk("R10 presc ignored", v, 16'd7);
    wr(2'd2, ctl(0, 1, 2'b10, 0));
    e0 = edge_seen;
    pin(1); rd16(v); chk("R10 sel1 rise no step", v, 16'd7);
    pin(0); rd16(v); chk("R10 falling", v, 16'd6);
    chk("R13 rising irq", edge_seen - e0, 1);

    // R11 width measurement
    wr(2'd2, ctl(1, 0, 2'b11, 0)); wr16(16'd100);
    wr(2'd2, ctl(0, 0, 2'b11, 0));
    pin(1); pulses(4); rd16(v); chk("R11 high counts", v, 16'd96);
    pin(0); pulses(4); rd16(v); chk("R11 low holds", v, 16'd96);
    wr(2'd2, ctl(0, 1, 2'b11, 0));
    pulses(3); rd16(v); chk("R11 sel1 low counts", v, 16'd93);
    pin(1); pulses(3); rd16(v); chk("R11 sel1 high holds", v, 16'd93);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule